// File: doc/BRIEF.md
# Conversion Mode and Calibration Sequencer

This block sits between the configuration registers of a sigma-delta converter and its data register. It decodes a 3-bit operating-mode field and runs idle, standby, continuous conversion, one-shot conversion and four calibration routines. It keeps three offset/gain coefficient pairs, chosen by the channel code. Every accepted raw filter result is corrected by first subtracting the pair's offset and then scaling by its gain. The corrected value is then coded as unipolar or bipolar output, clamped at both ends.

A raw result arrives as a signed value of DW+1 bits, where positive and negative full scale are +2^(DW-1) and -2^(DW-1). A strobe marks each result, and a second flag marks results from a fully settled filter. The gain coefficient is an unsigned fixed-point value with DW-1 fraction bits, so unity gain is 2^(DW-1). The front end reads `conv_run`, `stby`, `self_cal` and the effective fast-step/skip flags to decide what the modulator and filter do.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the mode field is 000, the channel is 0, bipolar coding is selected, the data output is 0 and `rdy_n` is 1. Every offset is 0 and every gain is 2^(DW-1).
- R2: Mode decode. `conv_run` is 1 for modes 001, 010 and 1xx. `stby` is 1 only for 011. `self_cal` is 1 for 100 and 101. 000 is idle.
- R3: In mode 001 each result strobe loads the data output and drives `rdy_n` to 0 on the same clock edge. A `data_rd` pulse sets `rdy_n` back to 1.
- R4: In mode 010 results without the settled flag are ignored. The first settled result loads the data output, drives `rdy_n` to 0 and sets the mode field to 000.
- R5: Writing any mode 1xx sets `rdy_n` to 1. In 100 or 110 the first settled result is stored as the offset of the selected pair, and on that edge the mode becomes 000 and `rdy_n` becomes 0. The data output is left untouched.
- R6: In 101 or 111 the first settled result r starts a gain computation g = floor(2^(2DW-2)/(r - offset)). When r - offset <= 2^(DW-2), g is all ones instead. g is written DW edges after the capture edge, and on that edge the mode becomes 000 and `rdy_n` becomes 0.
- R7: The coefficient pair is the channel code modulo 3. Codes 0/3/6, 1/4/7 and 2/5 share a pair.
- R8: The correction is p = (r - offset) * gain. Bipolar code = floor(p/2^(DW-1) + 1/2) + 2^(DW-1). Unipolar code = floor(p/2^(DW-2) + 1/2). Codes below 0 clamp to all zeros and codes above 2^DW-1 clamp to all ones.
- R9: A result accepted while `noref` is 1 loads all ones.
- R10: A mode write takes effect on its edge and abandons a running gain computation. The abandoned computation never writes a coefficient.
- R11: `eff_fast` and `eff_skip` follow `fast_en` and `skip_en`, but are forced to 0 while the mode is 1xx.
- R12: In modes 000 and 011 result strobes change neither the data output, `rdy_n` nor the mode.
- R13: A direct coefficient write stores `coef_wdata` as the offset, or its low DW bits as the gain (`coef_is_gain`=1), of the pair selected by `coef_chan` modulo 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 3 | New mode field |
| cfg_chan | input | 3 | New channel code |
| cfg_bipolar | input | 1 | 1 selects bipolar coding |
| coef_we | input | 1 | Coefficient write strobe |
| coef_is_gain | input | 1 | 1 writes gain, 0 writes offset |
| coef_chan | input | 3 | Channel code choosing the pair |
| coef_wdata | input | DW+1 | Coefficient value |
| raw_valid | input | 1 | Raw result strobe |
| raw_settled | input | 1 | Result is from a fully settled filter |
| raw_data | input | DW+1 | Signed raw result |
| noref | input | 1 | Reference missing |
| data_rd | input | 1 | Data register read completed |
| fast_en | input | 1 | Requested fast-step option |
| skip_en | input | 1 | Requested skip option |
| mode_q | output | 3 | Current mode field |
| data_out | output | DW | Data register |
| rdy_n | output | 1 | Low when an unread result or finished calibration is present |
| conv_run | output | 1 | Modulator and filter should run |
| stby | output | 1 | Standby state |
| self_cal | output | 1 | Front end applies internal calibration inputs |
| eff_fast | output | 1 | Effective fast-step option |
| eff_skip | output | 1 | Effective skip option |

## Verification
Conversions, offset calibrations, mode writes and coefficient writes all act on the edge that samples them. The bench drives each stimulus for one cycle from a falling edge and compares at the next falling edge. A gain calibration finishes DW edges after its capture edge. The bench therefore checks that the mode is still 1xx after DW-1 further edges and that it has returned to 000 after exactly DW. Corrected codes are swept over the entire raw range of a DW=8 instance for several gain and offset pairs in both codings, with each expected code computed arithmetically in the bench.

// File: rtl/adc_mode_seq.sv
module adc_mode_seq #(
  parameter int DW    = 24,
  parameter int NPAIR = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_mode,
  input  logic [2:0]           cfg_chan,
  input  logic                 cfg_bipolar,
  input  logic                 coef_we,
  input  logic                 coef_is_gain,
  input  logic [2:0]           coef_chan,
  input  logic [DW:0]          coef_wdata,
  input  logic                 raw_valid,
  input  logic                 raw_settled,
  input  logic signed [DW:0]   raw_data,
  input  logic                 noref,
  input  logic                 data_rd,
  input  logic                 fast_en,
  input  logic                 skip_en,
  output logic [2:0]           mode_q,
  output logic [DW-1:0]        data_out,
  output logic                 rdy_n,
  output logic                 conv_run,
  output logic                 stby,
  output logic                 self_cal,
  output logic                 eff_fast,
  output logic                 eff_skip
);
  localparam int RW   = DW + 1;
  localparam int CW   = DW + 2;
  localparam int PW   = CW + DW + 1;
  localparam int GF   = DW - 1;
  localparam int XW   = DW + 4;
  localparam int CNTW = $clog2(DW + 1);
  localparam int PIW  = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam logic signed [PW-1:0] HB   = PW'(1) <<< (GF - 1);
  localparam logic signed [PW-1:0] HU   = PW'(1) <<< (GF - 2);
  localparam logic signed [PW-1:0] MID  = PW'(1) <<< (DW - 1);
  localparam logic signed [PW-1:0] MAXC = (PW'(1) <<< DW) - PW'(1);
  localparam logic signed [CW-1:0] QLIM = CW'(1) <<< (DW - 2);
  localparam logic [XW-1:0]        REM0 = XW'(1) << (DW - 2);

  localparam logic [2:0] M_IDLE = 3'b000, M_CONT = 3'b001, M_SINGLE = 3'b010, M_STBY = 3'b011;

  logic signed [RW-1:0] off_r  [NPAIR];
  logic [DW-1:0]        gain_r [NPAIR];
  logic [2:0]           chan_q;
  logic                 bip_q;

  logic                 div_busy, div_sat;
  logic [CNTW-1:0]      div_cnt;
  logic [XW-1:0]        rem, dvs, rem2, rem_n;
  logic [DW-1:0]        quo, quo_n;
  logic                 ge;

  logic [PIW-1:0]       pair, cpair;
  logic signed [RW-1:0] off_cur;
  logic [DW-1:0]        gain_cur;
  logic signed [CW-1:0] diff;
  logic signed [PW-1:0] prod, lvl_b, lvl_u, lvl;
  logic [DW-1:0]        corr, upd;

  assign pair     = PIW'(chan_q % NPAIR);
  assign cpair    = PIW'(coef_chan % NPAIR);
  assign off_cur  = off_r[pair];
  assign gain_cur = gain_r[pair];

  assign diff  = {raw_data[DW], raw_data} - {off_cur[DW], off_cur};
  assign prod  = diff * $signed({1'b0, gain_cur});
  assign lvl_b = ((prod + HB) >>> GF) + MID;
  assign lvl_u = (prod + HU) >>> (GF - 1);
  assign lvl   = bip_q ? lvl_b : lvl_u;
  assign corr  = lvl[PW-1] ? '0 : ((lvl > MAXC) ? '1 : lvl[DW-1:0]);
  assign upd   = noref ? '1 : corr;

  assign rem2  = {rem[XW-2:0], 1'b0};
  assign ge    = (rem2 >= dvs);
  assign rem_n = ge ? rem2 - dvs : rem2;
  assign quo_n = {quo[DW-2:0], ge};

  assign conv_run = (mode_q == M_CONT) || (mode_q == M_SINGLE) || mode_q[2];
  assign stby     = (mode_q == M_STBY);
  assign self_cal = mode_q[2] & ~mode_q[1];
  assign eff_fast = fast_en & ~mode_q[2];
  assign eff_skip = skip_en & ~mode_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      chan_q   <= '0;
      bip_q    <= 1'b1;
      data_out <= '0;
      rdy_n    <= 1'b1;
      div_busy <= 1'b0;
      div_sat  <= 1'b0;
      div_cnt  <= '0;
      rem      <= '0;
      dvs      <= '0;
      quo      <= '0;
      for (int i = 0; i < NPAIR; i++) begin
        off_r[i]  <= '0;
        gain_r[i] <= DW'(1) << GF;
      end
    end else begin
      if (cfg_we) begin
        mode_q   <= cfg_mode;
        chan_q   <= cfg_chan;
        bip_q    <= cfg_bipolar;
        div_busy <= 1'b0;
        if (cfg_mode[2]) rdy_n <= 1'b1;
      end else begin
        if (data_rd) rdy_n <= 1'b1;
        if (div_busy) begin
          rem     <= rem_n;
          quo     <= quo_n;
          div_cnt <= div_cnt - CNTW'(1);
          if (div_cnt == CNTW'(1)) begin
            div_busy     <= 1'b0;
            gain_r[pair] <= div_sat ? '1 : quo_n;
            mode_q       <= M_IDLE;
            rdy_n        <= 1'b0;
          end
        end else if (raw_valid) begin
          case (mode_q)
            M_CONT: begin
              data_out <= upd;
              rdy_n    <= 1'b0;
            end
            M_SINGLE: if (raw_settled) begin
              data_out <= upd;
              rdy_n    <= 1'b0;
              mode_q   <= M_IDLE;
            end
            3'b100, 3'b110: if (raw_settled) begin
              off_r[pair] <= raw_data;
              mode_q      <= M_IDLE;
              rdy_n       <= 1'b0;
            end
            3'b101, 3'b111: if (raw_settled) begin
              div_busy <= 1'b1;
              div_sat  <= (diff <= QLIM);
              dvs      <= XW'(diff);
              rem      <= REM0;
              quo      <= '0;
              div_cnt  <= CNTW'(DW);
            end
            default: ;
          endcase
        end
      end
      if (coef_we) begin
        if (coef_is_gain) gain_r[cpair] <= coef_wdata[DW-1:0];
        else              off_r[cpair]  <= coef_wdata;
      end
    end
  end

  p_single_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !div_busy && mode_q == M_SINGLE && raw_valid && raw_settled)
    |=> (mode_q == M_IDLE && !rdy_n));

  p_cal_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_mode[2]) |=> (rdy_n && mode_q == $past(cfg_mode)));

  p_gain_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && div_cnt == CNTW'(1) && !cfg_we) |=> (mode_q == M_IDLE && !rdy_n));

  p_noref_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !div_busy && mode_q == M_CONT && raw_valid && noref)
    |=> (data_out == {DW{1'b1}} && !rdy_n));

  p_quiet_modes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !data_rd && (mode_q == M_IDLE || mode_q == M_STBY))
    |=> ($stable(data_out) && $stable(rdy_n) && $stable(mode_q)));

  p_abandon_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !div_busy);
endmodule

// File: tb/sim_adc_mode_seq.sv
module sim_adc_mode_seq;
  localparam int DW = 8;
  localparam int RW = DW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_bipolar = 1, coef_we = 0, coef_is_gain = 0;
  logic [2:0] cfg_mode = 0, cfg_chan = 0, coef_chan = 0;
  logic [DW:0] coef_wdata = 0;
  logic raw_valid = 0, raw_settled = 0, noref = 0, data_rd = 0, fast_en = 0, skip_en = 0;
  logic signed [DW:0] raw_data = 0;
  logic [2:0] mode_q;
  logic [DW-1:0] data_out;
  logic rdy_n, conv_run, stby, self_cal, eff_fast, eff_skip;

  int nchk = 0, nfail = 0;
  int offm[3], gainm[3];
  int last;
  bit done = 0;

  adc_mode_seq #(.DW(DW), .NPAIR(3)) u0 (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int r, input int pr, input bit bip);
    longint p, v;
    p = longint'(r - offm[pr]) * longint'(gainm[pr]);
    if (bip) v = ((p + (64'sd1 <<< (DW - 2))) >>> (DW - 1)) + (64'sd1 <<< (DW - 1));
    else     v = (p + (64'sd1 <<< (DW - 3))) >>> (DW - 2);
    if (v < 0) v = 0;
    if (v > (1 << DW) - 1) v = (1 << DW) - 1;
    return int'(v);
  endfunction

  function automatic int exp_gain(input int span);
    if (span <= (1 << (DW - 2))) return (1 << DW) - 1;
    return (1 << (2 * DW - 2)) / span;
  endfunction

  task automatic wr_mode(input logic [2:0] m, input logic [2:0] ch, input logic bp);
    cfg_mode = m; cfg_chan = ch; cfg_bipolar = bp; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push(input int r, input logic st, input logic nr);
    raw_data = RW'(r); raw_settled = st; noref = nr; raw_valid = 1;
    @(negedge clk); raw_valid = 0; raw_settled = 0; noref = 0;
  endtask

  task automatic coef(input logic g, input logic [2:0] ch, input int v);
    coef_is_gain = g; coef_chan = ch; coef_wdata = RW'(v); coef_we = 1;
    @(negedge clk); coef_we = 0;
  endtask

  task automatic read_out();
    data_rd = 1; @(negedge clk); data_rd = 0;
  endtask

  task automatic sweep(input logic [2:0] ch, input logic bp, input int step);
    wr_mode(3'b001, ch, bp);
    for (int r = -(1 << DW); r < (1 << DW); r += step) begin
      push(r, 0, 0);
      check($sformatf("R8 ch%0d bip%0d raw%0d", ch, bp, r), data_out, exp_code(r, ch % 3, bp));
    end
    check("R3 rdy_n low after result", rdy_n, 0);
    last = data_out;
  endtask

  task automatic gain_cal(input logic [2:0] m, input logic [2:0] ch, input int r);
    int pr;
    pr = ch % 3;
    wr_mode(m, ch, 1);
    check("R5 rdy_n high at calibration start", rdy_n, 1);
    push(r, 1, 0);
    repeat (DW - 1) @(negedge clk);
    check("R6 still calibrating one edge early", mode_q, m);
    @(negedge clk);
    check("R6 mode back to 000", mode_q, 0);
    check("R6 rdy_n low at end", rdy_n, 0);
    gainm[pr] = exp_gain(r - offm[pr]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin offm[i] = 0; gainm[i] = 1 << (DW - 1); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 mode", mode_q, 0);
    check("R1 data", data_out, 0);
    check("R1 rdy_n", rdy_n, 1);
    check("R1 conv_run", conv_run, 0);

    // R2 / R11 decode sweep
    fast_en = 1; skip_en = 1;
    for (int m = 0; m < 8; m++) begin
      wr_mode(3'(m), 0, 1);
      check($sformatf("R2 conv_run m%0d", m), conv_run, (m == 1 || m == 2 || m >= 4) ? 1 : 0);
      check($sformatf("R2 stby m%0d", m), stby, (m == 3) ? 1 : 0);
      check($sformatf("R2 self_cal m%0d", m), self_cal, (m == 4 || m == 5) ? 1 : 0);
      check($sformatf("R11 eff_fast m%0d", m), eff_fast, (m >= 4) ? 0 : 1);
      check($sformatf("R11 eff_skip m%0d", m), eff_skip, (m >= 4) ? 0 : 1);
    end
    fast_en = 0; skip_en = 0;
    wr_mode(3'b000, 0, 1);

    // R8 default coefficients, both codings
    sweep(0, 1, 1);
    sweep(0, 0, 1);
    read_out();
    check("R3 rdy_n high after read", rdy_n, 1);

    // R5 zero-scale calibration on channel 4 (pair 1)
    wr_mode(3'b100, 4, 1);
    check("R5 rdy_n high at start", rdy_n, 1);
    push(-20, 0, 0);
    check("R5 unsettled result ignored", mode_q, 3'b100);
    push(-20, 1, 0);
    check("R5 mode back to 000", mode_q, 0);
    check("R5 rdy_n low", rdy_n, 0);
    check("R5 data untouched", data_out, last);
    offm[1] = -20;

    // R6 gain calibration sweep incl. saturation
    begin
      int rl[6] = '{255, 150, 108, 45, 44, -100};
      for (int k = 0; k < 6; k++) begin
        gain_cal((k % 2) ? 3'b101 : 3'b111, 1, rl[k]);
        sweep(1, 1, 5);
        sweep(1, 0, 7);
      end
    end

    // R7 pair mapping via system zero-scale calibration
    for (int c = 0; c < 3; c++) begin
      wr_mode(3'b110, 3'(c), 1);
      push(10 * (c + 1), 1, 0);
      offm[c] = 10 * (c + 1);
    end
    for (int c = 0; c < 8; c++) begin
      wr_mode(3'b001, 3'(c), 1);
      push(100, 0, 0);
      check($sformatf("R7 ch%0d", c), data_out, exp_code(100, c % 3, 1));
    end

    // R13 direct coefficient writes through shared channel codes
    coef(1, 3'd5, 64);  gainm[2] = 64;
    coef(0, 3'd3, 5);   offm[0] = 5;
    coef(0, 3'd7, -30); offm[1] = -30;
    sweep(2, 1, 3);
    sweep(6, 0, 3);
    sweep(4, 1, 9);

    // R4 single conversion
    wr_mode(3'b010, 0, 1);
    last = data_out;
    push(50, 0, 0);
    check("R4 unsettled ignored data", data_out, last);
    check("R4 unsettled ignored mode", mode_q, 3'b010);
    read_out();
    push(60, 1, 0);
    check("R4 settled result", data_out, exp_code(60, 0, 1));
    check("R4 mode cleared", mode_q, 0);
    check("R4 rdy_n low", rdy_n, 0);
    last = data_out;
    push(70, 1, 0);
    check("R12 idle ignores result", data_out, last);
    check("R12 idle rdy_n", rdy_n, 0);

    // R9 no reference
    wr_mode(3'b001, 2, 0);
    push(-200, 0, 1);
    check("R9 continuous all ones", data_out, 255);
    wr_mode(3'b010, 1, 1);
    push(-200, 1, 1);
    check("R9 single all ones", data_out, 255);

    // R10 abandon gain calibration
    wr_mode(3'b101, 0, 1);
    push(100, 1, 0);
    repeat (3) @(negedge clk);
    wr_mode(3'b001, 0, 1);
    check("R10 new mode immediate", mode_q, 3'b001);
    repeat (DW + 2) @(negedge clk);
    check("R10 mode kept", mode_q, 3'b001);
    sweep(0, 1, 11);

    // R12 standby ignores results
    wr_mode(3'b011, 0, 1);
    read_out();
    last = data_out;
    push(17, 1, 0);
    check("R12 standby data", data_out, last);
    check("R12 standby rdy_n", rdy_n, 1);
    check("R12 standby mode", mode_q, 3'b011);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule